// File: doc/BRIEF.md
# Dual-Reset Control Register Bank

This block is a small bank of control and status registers that a processor reaches over a simple synchronous bus. Every bit is given one of five access behaviours: plain read-write, read-only, read-write that hardware may also update, self-clearing, or write-one-to-clear. The access behaviour, the reset value and the retention choice are set per bit through parameters. Peripheral logic reads every stored bit on a flat output vector. It also receives a one-cycle strobe for each self-clearing bit. In the other direction, it raises status events and updates hardware-owned bits through per-bit inputs.

Two active-low reset inputs are provided. The power-on reset returns every bit to its reset value. The warm reset covers resets that happen while power stays on, such as wake-up from low power, brown-out detection, illegal operation traps or re-enabling a block. It clears only the bits that are not marked as retained, and retained bits keep their contents through it.

Registers sit at word addresses 0 to NUM_REGS-1. Any other address reads as zero. Read data is registered and appears one cycle after the read strobe.

Top module: `dualrst_regbank`

## Requirements
- R1: With por_n low, every stored bit takes its parameter reset value (default bank: reg_q = 0x5AA00000, with register 0 in bits 7:0).
- R2: While por_n is high, a pulse of warm_n low leaves every bit whose RETAIN_MASK bit is 1 unchanged (default retained bits: reg0 7:4, reg1 bits 7, 3 and 2, reg3 3:0).
- R3: While por_n is high, a pulse of warm_n low returns every bit whose RETAIN_MASK bit is 0 to its reset value.
- R4: A bus write has no effect on a read-only bit (default reg1 bits 5:4). The bit loads hw_val only when hw_upd is high for that bit.
- R5: Writing a one to a self-clearing bit (default reg2 bits 3:0) raises its sc_pulse bit during that same write cycle only. Such a bit always reads as zero and shows zero on reg_q.
- R6: A write-one-to-clear bit (default reg1 bits 3:0) is set by hw_set and cleared by a bus write with a one in its position. A zero in its position leaves it unchanged.
- R7: When hw_set and a clearing write reach the same write-one-to-clear bit in one cycle, the bit ends up set.
- R8: A hardware-updated read-write bit (default reg1 bits 7:6) loads write data on a bus write and hw_val when hw_upd is high. If both happen in the same cycle, hw_val is loaded.
- R9: A read-write bit (default reg0, reg2 bits 7:4, reg3) loads the write data bit on a bus write and ignores the hardware inputs.
- R10: A read of an address at or above NUM_REGS returns zero.
- R11: rdata presents the addressed register one cycle after a cycle with rd_en high. It is zero after any cycle with rd_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| warm_n | input | 1 | Warm reset, active low, clears non-retained bits |
| addr | input | ADDR_W | Word address of the access |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W | Registered read data |
| hw_set | input | NUM_REGS*DATA_W | Per-bit event set for write-one-to-clear bits |
| hw_upd | input | NUM_REGS*DATA_W | Per-bit hardware load enable for read-only and hardware-updated bits |
| hw_val | input | NUM_REGS*DATA_W | Per-bit hardware load value |
| reg_q | output | NUM_REGS*DATA_W | Stored value of every bit, register i in bits i*DATA_W upward |
| sc_pulse | output | NUM_REGS*DATA_W | One-cycle strobe for each self-clearing bit written with one |

## Verification
The hardest situations to reach are the same-cycle collisions, where a bus write and a hardware event land on the same bit. In one case a clearing write meets hw_set. In the other, write data meets hw_upd. The bench drives the hardware inputs in the exact low phase in which it raises wr_en, so that both reach the same rising edge. For retention, the bench first loads each register with a pattern that mixes ones and zeros across both retained and non-retained bits. It then pulses warm_n alone and compares the whole reg_q vector, so a bit that loses its value and a bit that fails to clear both show up.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [2:0] {
    ACC_RW  = 3'd0,
    ACC_RO  = 3'd1,
    ACC_HW  = 3'd2,
    ACC_SC  = 3'd3,
    ACC_W1C = 3'd4
  } acc_e;

  // Resolve overlapping mask bits by a fixed precedence.
  function automatic acc_e acc_pick(input logic ro, input logic hw,
                                    input logic sc, input logic w1c);
    acc_e a;
    if (sc)       a = ACC_SC;
    else if (w1c) a = ACC_W1C;
    else if (ro)  a = ACC_RO;
    else if (hw)  a = ACC_HW;
    else          a = ACC_RW;
    return a;
  endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                rd_en,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic                hit
);

  logic [NUM_REGS-1:0] match;

  genvar i;
  generate
    for (i = 0; i < NUM_REGS; i++) begin : g_match
      assign match[i] = (addr == ADDR_W'(i));
    end
  endgenerate

  always_comb begin
    hit    = |match;
    wr_sel = wr_en ? match : '0;
    rd_sel = rd_en ? match : '0;
  end

endmodule

// File: rtl/regbank_bit.sv
module regbank_bit
  import regbank_pkg::*;
#(
  parameter acc_e ACC     = ACC_RW,
  parameter logic RST_VAL = 1'b0,
  parameter logic RETAIN  = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic warm_n,
  input  logic wr,
  input  logic wbit,
  input  logic hw_set,
  input  logic hw_upd,
  input  logic hw_val,
  output logic q,
  output logic rbit,
  output logic pulse
);

  logic rst_n;
  logic q_r;
  logic en;
  logic d;

  // Retained bits see only the power-on reset.
  assign rst_n = RETAIN ? por_n : (por_n & warm_n);

  // Next-state selection for the configured access type.
  always_comb begin
    en = 1'b0;
    d  = q_r;
    case (ACC)
      ACC_RW: begin
        en = wr;
        d  = wbit;
      end
      ACC_RO: begin
        en = hw_upd;
        d  = hw_val;
      end
      ACC_HW: begin
        en = wr | hw_upd;
        d  = hw_upd ? hw_val : wbit;
      end
      ACC_W1C: begin
        en = hw_set | (wr & wbit);
        d  = hw_set;
      end
      default: begin
        en = 1'b0;
        d  = q_r;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= (ACC == ACC_SC) ? 1'b0 : RST_VAL;
    else if (en) q_r <= d;
  end

  always_comb begin
    q     = (ACC == ACC_SC) ? 1'b0 : q_r;
    rbit  = q;
    pulse = (ACC == ACC_SC) ? (wr & wbit) : 1'b0;
  end

  p_rw_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ACC == ACC_RW && wr) |=> (q == $past(wbit)));

  p_ro_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ACC == ACC_RO && !hw_upd) |=> $stable(q));

  p_w1c_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ACC == ACC_W1C && !hw_set && !(wr && wbit)) |=> $stable(q));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ACC == ACC_W1C && hw_set) |=> q);

  p_hw_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ACC == ACC_HW && hw_upd) |=> (q == $past(hw_val)));

  p_sc_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ACC == ACC_SC) |-> (!rbit && !q));

endmodule

// File: rtl/regbank_reg.sv
module regbank_reg
  import regbank_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter logic [DATA_W-1:0] RO_MASK  = '0,
  parameter logic [DATA_W-1:0] HW_MASK  = '0,
  parameter logic [DATA_W-1:0] SC_MASK  = '0,
  parameter logic [DATA_W-1:0] W1C_MASK = '0,
  parameter logic [DATA_W-1:0] RST_VAL  = '0,
  parameter logic [DATA_W-1:0] RETAIN   = '0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  input  logic [DATA_W-1:0] hw_upd,
  input  logic [DATA_W-1:0] hw_val,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] rval,
  output logic [DATA_W-1:0] pulse
);

  genvar b;
  generate
    for (b = 0; b < DATA_W; b++) begin : g_bit
      regbank_bit #(
        .ACC     (acc_pick(RO_MASK[b], HW_MASK[b], SC_MASK[b], W1C_MASK[b])),
        .RST_VAL (RST_VAL[b]),
        .RETAIN  (RETAIN[b])
      ) u_bit (
        .clk    (clk),
        .por_n  (por_n),
        .warm_n (warm_n),
        .wr     (wr),
        .wbit   (wdata[b]),
        .hw_set (hw_set[b]),
        .hw_upd (hw_upd[b]),
        .hw_val (hw_val[b]),
        .q      (q[b]),
        .rbit   (rval[b]),
        .pulse  (pulse[b])
      );
    end
  endgenerate

endmodule

// File: rtl/dualrst_regbank.sv
module dualrst_regbank #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter logic [NUM_REGS*DATA_W-1:0] RO_MASK     = 32'h0000_3000,
  parameter logic [NUM_REGS*DATA_W-1:0] HW_MASK     = 32'h0000_C000,
  parameter logic [NUM_REGS*DATA_W-1:0] SC_MASK     = 32'h000F_0000,
  parameter logic [NUM_REGS*DATA_W-1:0] W1C_MASK    = 32'h0000_0F00,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VAL   = 32'h5AA0_0000,
  parameter logic [NUM_REGS*DATA_W-1:0] RETAIN_MASK = 32'h0F00_8CF0
) (
  input  logic                         clk,
  input  logic                         por_n,
  input  logic                         warm_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         wr_en,
  input  logic                         rd_en,
  output logic [DATA_W-1:0]            rdata,
  input  logic [NUM_REGS*DATA_W-1:0]   hw_set,
  input  logic [NUM_REGS*DATA_W-1:0]   hw_upd,
  input  logic [NUM_REGS*DATA_W-1:0]   hw_val,
  output logic [NUM_REGS*DATA_W-1:0]   reg_q,
  output logic [NUM_REGS*DATA_W-1:0]   sc_pulse
);

  localparam int FLAT_W = NUM_REGS * DATA_W;

  logic [NUM_REGS-1:0] wr_sel;
  logic [NUM_REGS-1:0] rd_sel;
  logic                rd_hit;
  logic [FLAT_W-1:0]   rval_flat;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   rdata_d;
  logic [DATA_W-1:0]   rdata_q;
  logic                rd_rst_n;

  regbank_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_decode (
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel),
    .hit    (rd_hit)
  );

  genvar r;
  generate
    for (r = 0; r < NUM_REGS; r++) begin : g_reg
      regbank_reg #(
        .DATA_W   (DATA_W),
        .RO_MASK  (RO_MASK    [r*DATA_W +: DATA_W]),
        .HW_MASK  (HW_MASK    [r*DATA_W +: DATA_W]),
        .SC_MASK  (SC_MASK    [r*DATA_W +: DATA_W]),
        .W1C_MASK (W1C_MASK   [r*DATA_W +: DATA_W]),
        .RST_VAL  (RESET_VAL  [r*DATA_W +: DATA_W]),
        .RETAIN   (RETAIN_MASK[r*DATA_W +: DATA_W])
      ) u_reg (
        .clk    (clk),
        .por_n  (por_n),
        .warm_n (warm_n),
        .wr     (wr_sel[r]),
        .wdata  (wdata),
        .hw_set (hw_set[r*DATA_W +: DATA_W]),
        .hw_upd (hw_upd[r*DATA_W +: DATA_W]),
        .hw_val (hw_val[r*DATA_W +: DATA_W]),
        .q      (reg_q[r*DATA_W +: DATA_W]),
        .rval   (rval_flat[r*DATA_W +: DATA_W]),
        .pulse  (sc_pulse[r*DATA_W +: DATA_W])
      );
    end
  endgenerate

  // Read path: OR of selected registers, zero when unmapped or idle.
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_sel[k]) rd_mux = rd_mux | rval_flat[k*DATA_W +: DATA_W];
    end
    rdata_d = (rd_en && rd_hit) ? rd_mux : '0;
  end

  assign rd_rst_n = por_n & warm_n;

  always_ff @(posedge clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rdata_q <= '0;
    else           rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rd_rst_n)
    (rd_en && !rd_hit) |=> (rdata == '0));

  p_rd_idle_zero_r11: assert property (@(posedge clk) disable iff (!rd_rst_n)
    (!rd_en) |=> (rdata == '0));

  p_sc_strobe_needs_write_r5: assert property (@(posedge clk) disable iff (!rd_rst_n)
    (!wr_en) |-> (sc_pulse == '0));

endmodule

// File: tb/dualrst_regbank_test.sv
module dualrst_regbank_test;

  logic        clk;
  logic        por_n;
  logic        warm_n;
  logic [3:0]  addr;
  logic [7:0]  wdata;
  logic        wr_en;
  logic        rd_en;
  logic [7:0]  rdata;
  logic [31:0] hw_set;
  logic [31:0] hw_upd;
  logic [31:0] hw_val;
  logic [31:0] reg_q;
  logic [31:0] sc_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  dualrst_regbank uut (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .hw_set(hw_set),
    .hw_upd(hw_upd), .hw_val(hw_val), .reg_q(reg_q), .sc_pulse(sc_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic test_por;
    logic [7:0] v;
    check("R1 reg_q after power-on reset", reg_q, 32'h5AA0_0000);
    bus_read(4'd2, v); check("R1 read reg2 reset", {24'h0, v}, 32'hA0);
    bus_read(4'd3, v); check("R1 read reg3 reset", {24'h0, v}, 32'h5A);
  endtask

  task automatic test_rw;
    logic [7:0] v;
    hw_upd = 32'h0000_00FF; hw_val = 32'h0000_00FF; hw_set = 32'h0000_00FF;
    bus_write(4'd0, 8'h3C);
    hw_upd = '0; hw_val = '0; hw_set = '0;
    bus_read(4'd0, v); check("R9 reg0 write, hw inputs ignored", {24'h0, v}, 32'h3C);
    bus_write(4'd3, 8'hC3);
    bus_read(4'd3, v); check("R9 reg3 write", {24'h0, v}, 32'hC3);
    @(negedge clk); check("R11 rdata zero when idle", {24'h0, rdata}, 32'h0);
  endtask

  task automatic test_ro_hw;
    logic [7:0] v;
    bus_write(4'd1, 8'hFF);
    bus_read(4'd1, v); check("R4/R8 ro bits ignore write, hw bits load", {24'h0, v}, 32'hC0);
    @(negedge clk); hw_upd = 32'h0000_3000; hw_val = 32'h0000_3000;
    @(negedge clk); hw_upd = '0; hw_val = '0;
    bus_read(4'd1, v); check("R4 ro bits load from hardware", {24'h0, v}, 32'hF0);
    bus_write(4'd1, 8'h00);
    bus_read(4'd1, v); check("R4 ro bits keep value on zero write", {24'h0, v}, 32'h30);
  endtask

  task automatic test_sc;
    logic [7:0] v;
    @(negedge clk); addr = 4'd2; wdata = 8'hA5; wr_en = 1'b1;
    #5 check("R5 pulse in write cycle", sc_pulse, 32'h0005_0000);
    @(negedge clk); wr_en = 1'b0;
    #5 check("R5 pulse gone next cycle", sc_pulse, 32'h0);
    bus_read(4'd2, v); check("R5 sc bits read zero", {24'h0, v}, 32'hA0);
  endtask

  task automatic test_w1c;
    logic [7:0] v;
    @(negedge clk); hw_set = 32'h0000_0F00;
    @(negedge clk); hw_set = '0;
    bus_read(4'd1, v); check("R6 hw_set raises status", {24'h0, v}, 32'h3F);
    bus_write(4'd1, 8'h05);
    bus_read(4'd1, v); check("R6 ones clear", {24'h0, v}, 32'h3A);
    bus_write(4'd1, 8'h00);
    bus_read(4'd1, v); check("R6 zeros leave status", {24'h0, v}, 32'h3A);
  endtask

  task automatic test_collide;
    logic [7:0] v;
    @(negedge clk); addr = 4'd1; wdata = 8'h02; wr_en = 1'b1; hw_set = 32'h0000_0200;
    @(negedge clk); wr_en = 1'b0; hw_set = '0;
    bus_read(4'd1, v); check("R7 set wins over clear", {24'h0, v}, 32'h3A);
    @(negedge clk); addr = 4'd1; wdata = 8'h80; wr_en = 1'b1;
    hw_upd = 32'h0000_C000; hw_val = 32'h0000_4000;
    @(negedge clk); wr_en = 1'b0; hw_upd = '0; hw_val = '0;
    bus_read(4'd1, v); check("R8 hardware wins over write", {24'h0, v}, 32'h7A);
  endtask

  task automatic test_unmapped;
    logic [7:0] v;
    bus_read(4'd4, v);  check("R10 unmapped 4", {24'h0, v}, 32'h0);
    bus_read(4'd15, v); check("R10 unmapped 15", {24'h0, v}, 32'h0);
    @(negedge clk); check("R11 idle after read", {24'h0, rdata}, 32'h0);
  endtask

  task automatic test_resets;
    check("R2 state before warm reset", reg_q, 32'hC3A0_7A3C);
    @(negedge clk); warm_n = 1'b0;
    @(negedge clk); warm_n = 1'b1;
    #5 check("R2/R3 retained kept, others reset", reg_q, 32'h53A0_0830);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    #5 check("R1 power-on reset restores all", reg_q, 32'h5AA0_0000);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    por_n = 1'b0; warm_n = 1'b1; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    hw_set = '0; hw_upd = '0; hw_val = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    test_por();
    test_rw();
    test_ro_hw();
    test_sc();
    test_w1c();
    test_collide();
    test_unmapped();
    test_resets();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule